// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Decimal Correction

This block is the purely combinational datapath of a small 8-bit controller core. It takes the accumulator value, a second operand, the three incoming status flags (carry, auxiliary carry, overflow) and a 4-bit operation code. In the same cycle it returns the new accumulator value and the three outgoing flags. The surrounding core fetches the operands, stores the results and handles multiply and divide.

The unit covers binary add, add with carry in, subtract with borrow in, increment and decrement, the three bitwise logic operations, clear and complement, rotation in an 8-bit ring or in a 9-bit ring that includes the carry, nibble exchange, and decimal correction after adding two packed BCD bytes. The core writes the outgoing flags back every cycle, so any operation that leaves a flag alone passes the incoming value through unchanged.

Top module: `acc_alu`

## Requirements
- R1: Operation codes on `op_i`: 0 add, 1 add-with-carry, 2 subtract-with-borrow, 3 increment, 4 decrement, 5 AND, 6 OR, 7 XOR, 8 clear, 9 complement, 10 rotate left, 11 rotate left through carry, 12 rotate right, 13 rotate right through carry, 14 nibble swap, 15 decimal adjust. Code 0 returns (A + B) mod 256, sets `cy_o` to the carry out of bit 7, and ignores `cy_i`.
- R2: Code 1 returns (A + B + `cy_i`) mod 256, and `cy_o` is the carry out of bit 7.
- R3: Code 2 returns (A - B - `cy_i`) mod 256, and `cy_o` is 1 exactly when that difference is negative (a borrow into bit 7).
- R4: For codes 0 to 2, `ac_o` is the carry out of bit 3 (add forms), or the borrow into bit 3 (subtract), of the same low-nibble operation including the carry or borrow term.
- R5: For codes 0 to 2, `ov_o` is 1 exactly when the signed two's-complement result falls outside -128..127.
- R6: Codes 3 and 4 return A + 1 and A - 1 modulo 256, with all three flags equal to their inputs.
- R7: Codes 5, 6 and 7 return the bitwise AND, OR and XOR of A and B, with all flags unchanged.
- R8: Code 8 returns 0 and code 9 returns the bitwise inverse of A, with all flags unchanged.
- R9: Codes 10 and 12 rotate A by one place in an 8-bit ring (bit 7 enters bit 0, or bit 0 enters bit 7), with all flags unchanged.
- R10: Code 11 returns {A[6:0], `cy_i`} with `cy_o` = A[7]; code 13 returns {`cy_i`, A[7:1]} with `cy_o` = A[0]; `ac_o` and `ov_o` are unchanged.
- R11: Code 14 returns {A[3:0], A[7:4]} with all flags unchanged.
- R12: Code 15 first adds 6 to A when A[3:0] > 9 or `ac_i` is 1; it then adds 0x60 when the upper nibble of that sum is > 9, or `cy_i` is 1, or the first step carried out of bit 7.
- R13: Under code 15, `cy_o` is 1 if `cy_i` is 1 or either correction step carries out of bit 7, and is otherwise 0; `ac_o` and `ov_o` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_i | input | 8 | Accumulator operand A |
| opnd_i | input | 8 | Second operand B |
| cy_i | input | 1 | Incoming carry flag |
| ac_i | input | 1 | Incoming auxiliary (bit 3) carry flag |
| ov_i | input | 1 | Incoming overflow flag |
| op_i | input | 4 | Operation code (see R1) |
| res_o | output | 8 | New accumulator value |
| cy_o | output | 1 | Outgoing carry flag |
| ac_o | output | 1 | Outgoing auxiliary carry flag |
| ov_o | output | 1 | Outgoing overflow flag |

## Verification
The unit contains no registers, so every result and flag is due in the same cycle in which its operands and operation code are presented. The driver task applies each stimulus on a falling clock edge and queues the expected result. The monitor takes that entry off the queue on the next rising edge, half a period later, when the combinational outputs have long been stable and no input is changing. Each queued item therefore matches exactly one stimulus, and none is compared before its inputs are in place.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_SUBB = 4'd2,
        OP_INC  = 4'd3,
        OP_DEC  = 4'd4,
        OP_AND  = 4'd5,
        OP_OR   = 4'd6,
        OP_XOR  = 4'd7,
        OP_CLR  = 4'd8,
        OP_CPL  = 4'd9,
        OP_RL   = 4'd10,
        OP_RLC  = 4'd11,
        OP_RR   = 4'd12,
        OP_RRC  = 4'd13,
        OP_SWAP = 4'd14,
        OP_DA   = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic cy;
        logic ac;
        logic ov;
    } alu_flags_t;

    // True for operations whose result comes from the adder and updates all flags
    function automatic logic op_sets_arith_flags(input alu_op_e op);
        return (op == OP_ADD) || (op == OP_ADDC) || (op == OP_SUBB);
    endfunction

    // True for operations that leave every flag at its incoming value
    function automatic logic op_keeps_flags(input alu_op_e op);
        return !op_sets_arith_flags(op) && (op != OP_RLC) &&
               (op != OP_RRC) && (op != OP_DA);
    endfunction

endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cy_i,
    input  alu_op_e           op_i,
    output logic [DATA_W-1:0] sum_o,
    output alu_flags_t        fl_o
);
    localparam int HALF = DATA_W / 2;
    localparam int MSB  = DATA_W - 1;

    logic              is_sub;
    logic              use_cy;
    logic              c0;
    logic [DATA_W-1:0] b_sel;
    logic [DATA_W-1:0] b_eff;
    logic [HALF:0]     low_sum;
    logic [DATA_W:0]   full_sum;

    always_comb begin
        is_sub = (op_i == OP_SUBB) || (op_i == OP_DEC);
        use_cy = (op_i == OP_ADDC) || (op_i == OP_SUBB);
        b_sel  = ((op_i == OP_INC) || (op_i == OP_DEC)) ? DATA_W'(1) : b_i;
        b_eff  = is_sub ? ~b_sel : b_sel;
        // subtract as A + ~B + 1 - borrow
        c0     = is_sub ? ~(use_cy & cy_i) : (use_cy & cy_i);

        low_sum  = {1'b0, a_i[HALF-1:0]} + {1'b0, b_eff[HALF-1:0]}
                 + {{HALF{1'b0}}, c0};
        full_sum = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, c0};

        sum_o    = full_sum[DATA_W-1:0];
        fl_o.cy  = is_sub ? ~full_sum[DATA_W] : full_sum[DATA_W];
        fl_o.ac  = is_sub ? ~low_sum[HALF] : low_sum[HALF];
        fl_o.ov  = (a_i[MSB] == b_eff[MSB]) && (full_sum[MSB] != a_i[MSB]);
    end

endmodule

// File: rtl/acc_alu_bitops.sv
module acc_alu_bitops
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cy_i,
    input  alu_op_e           op_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cy_o
);
    localparam int HALF = DATA_W / 2;
    localparam int MSB  = DATA_W - 1;

    logic [DATA_W-1:0] swapped;

    genvar g;
    generate
        for (g = 0; g < HALF; g++) begin : g_swap
            assign swapped[g]        = a_i[g + HALF];
            assign swapped[g + HALF] = a_i[g];
        end
    endgenerate

    always_comb begin
        res_o = a_i;
        cy_o  = cy_i;
        unique case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_CLR:  res_o = '0;
            OP_CPL:  res_o = ~a_i;
            OP_RL:   res_o = {a_i[MSB-1:0], a_i[MSB]};
            OP_RR:   res_o = {a_i[0], a_i[MSB:1]};
            OP_RLC: begin
                res_o = {a_i[MSB-1:0], cy_i};
                cy_o  = a_i[MSB];
            end
            OP_RRC: begin
                res_o = {cy_i, a_i[MSB:1]};
                cy_o  = a_i[0];
            end
            OP_SWAP: res_o = swapped;
            default: res_o = a_i;
        endcase
    end

endmodule

// File: rtl/acc_alu_decadj.sv
module acc_alu_decadj #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic              cy_i,
    input  logic              ac_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cy_o
);
    localparam int          HALF     = DATA_W / 2;
    localparam logic [DATA_W:0] LOW_SIX  = (DATA_W + 1)'(6);
    localparam logic [DATA_W:0] HIGH_SIX = (DATA_W + 1)'(6) << HALF;
    localparam logic [HALF-1:0] NINE     = HALF'(9);

    logic            fix_low;
    logic            fix_high;
    logic [DATA_W:0] step1;
    logic [DATA_W:0] step2;

    always_comb begin
        fix_low  = ac_i || (a_i[HALF-1:0] > NINE);
        step1    = {1'b0, a_i} + (fix_low ? LOW_SIX : '0);
        fix_high = cy_i || step1[DATA_W] || (step1[DATA_W-1:HALF] > NINE);
        step2    = {1'b0, step1[DATA_W-1:0]} + (fix_high ? HIGH_SIX : '0);
        res_o    = step2[DATA_W-1:0];
        cy_o     = cy_i | step1[DATA_W] | step2[DATA_W];
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] opnd_i,
    input  logic              cy_i,
    input  logic              ac_i,
    input  logic              ov_i,
    input  logic [3:0]        op_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cy_o,
    output logic              ac_o,
    output logic              ov_o
);
    localparam int HALF = DATA_W / 2;
    localparam int MSB  = DATA_W - 1;

    alu_op_e           op;
    alu_flags_t        fl_in;
    alu_flags_t        fl_arith;
    alu_flags_t        fl_out;
    logic [DATA_W-1:0] sum;
    logic [DATA_W-1:0] bit_res;
    logic              bit_cy;
    logic [DATA_W-1:0] da_res;
    logic              da_cy;

    assign op    = alu_op_e'(op_i);
    assign fl_in = '{cy: cy_i, ac: ac_i, ov: ov_i};

    acc_alu_arith #(.DATA_W(DATA_W)) u_arith (
        .a_i   (acc_i),
        .b_i   (opnd_i),
        .cy_i  (cy_i),
        .op_i  (op),
        .sum_o (sum),
        .fl_o  (fl_arith)
    );

    acc_alu_bitops #(.DATA_W(DATA_W)) u_bitops (
        .a_i   (acc_i),
        .b_i   (opnd_i),
        .cy_i  (cy_i),
        .op_i  (op),
        .res_o (bit_res),
        .cy_o  (bit_cy)
    );

    acc_alu_decadj #(.DATA_W(DATA_W)) u_decadj (
        .a_i   (acc_i),
        .cy_i  (cy_i),
        .ac_i  (ac_i),
        .res_o (da_res),
        .cy_o  (da_cy)
    );

    always_comb begin
        fl_out = fl_in;
        if (op_sets_arith_flags(op)) begin
            res_o  = sum;
            fl_out = fl_arith;
        end else if ((op == OP_INC) || (op == OP_DEC)) begin
            res_o  = sum;
        end else if (op == OP_DA) begin
            res_o     = da_res;
            fl_out.cy = da_cy;
        end else begin
            res_o     = bit_res;
            fl_out.cy = bit_cy;
        end
        cy_o = fl_out.cy;
        ac_o = fl_out.ac;
        ov_o = fl_out.ov;
    end

    // Checks on the assembled outputs against the unit inputs
    always_comb begin
        if (op_keeps_flags(op))
            AST_FLAGS_HELD: assert ((cy_o == cy_i) && (ac_o == ac_i) && (ov_o == ov_i)); // R7
        if (op == OP_CLR)
            AST_CLEAR_ZERO: assert (res_o == '0); // R8
        if (op == OP_CPL)
            AST_COMPLEMENT_ALL: assert ((res_o ^ acc_i) == '1); // R8
        if (op == OP_SWAP)
            AST_SWAP_HALVES: assert ((res_o[HALF-1:0] == acc_i[MSB:HALF]) && (res_o[MSB:HALF] == acc_i[HALF-1:0])); // R11
        if (op == OP_RLC)
            AST_RLC_RING: assert ((cy_o == acc_i[MSB]) && (res_o[0] == cy_i)); // R10
        if (op == OP_RRC)
            AST_RRC_RING: assert ((cy_o == acc_i[0]) && (res_o[MSB] == cy_i)); // R10
        if (op == OP_RL)
            AST_RL_RING: assert (res_o[0] == acc_i[MSB]); // R9
        if ((op == OP_DA) && cy_i)
            AST_DA_CARRY_STICKY: assert (cy_o); // R13
        if (op == OP_ADD)
            AST_ADD_SUM: assert ({cy_o, res_o} == ({1'b0, acc_i} + {1'b0, opnd_i})); // R1
    end

endmodule

// File: tb/acc_alu_bench.sv
module acc_alu_bench;

    typedef struct {
        logic [7:0] res;
        logic       cy;
        logic       ac;
        logic       ov;
        string      tag;
    } exp_t;

    logic       clk;
    logic       rst;
    logic [7:0] acc_i;
    logic [7:0] opnd_i;
    logic       cy_i;
    logic       ac_i;
    logic       ov_i;
    logic [3:0] op_i;
    logic [7:0] res_o;
    logic       cy_o;
    logic       ac_o;
    logic       ov_o;

    int   n_checks = 0;
    int   n_errors = 0;
    int   cycles   = 0;
    exp_t sb_q[$];

    acc_alu u_acc_alu (
        .acc_i  (acc_i),
        .opnd_i (opnd_i),
        .cy_i   (cy_i),
        .ac_i   (ac_i),
        .ov_i   (ov_i),
        .op_i   (op_i),
        .res_o  (res_o),
        .cy_o   (cy_o),
        .ac_o   (ac_o),
        .ov_o   (ov_o)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    function automatic exp_t model(input int op, input int a, input int b,
                                   input int cy, input int ac, input int ov,
                                   input string tag);
        exp_t e;
        int r, cin, sa, sb, sr, c, lo;
        e.cy = cy[0]; e.ac = ac[0]; e.ov = ov[0]; e.tag = tag;
        r = a;
        case (op)
            0, 1: begin
                cin = (op == 1) ? cy : 0;
                r  = a + b + cin;
                lo = (a % 16) + (b % 16) + cin;
                sa = (a > 127) ? a - 256 : a;
                sb = (b > 127) ? b - 256 : b;
                sr = sa + sb + cin;
                e.cy = (r > 255); e.ac = (lo > 15); e.ov = (sr > 127) || (sr < -128);
            end
            2: begin
                r  = a - b - cy;
                lo = (a % 16) - (b % 16) - cy;
                sa = (a > 127) ? a - 256 : a;
                sb = (b > 127) ? b - 256 : b;
                sr = sa - sb - cy;
                e.cy = (r < 0); e.ac = (lo < 0); e.ov = (sr > 127) || (sr < -128);
                r = r + 256;
            end
            3: r = a + 1;
            4: r = a + 255;
            5: r = a & b;
            6: r = a | b;
            7: r = a ^ b;
            8: r = 0;
            9: r = 255 - a;
            10: r = (a * 2) + (a / 128);
            11: begin r = (a * 2) + cy; e.cy = (a / 128) != 0; end
            12: r = (a / 2) + (a % 2) * 128;
            13: begin r = (a / 2) + cy * 128; e.cy = (a % 2) != 0; end
            14: r = (a % 16) * 16 + (a / 16);
            default: begin
                c = cy;
                if ((a % 16) > 9 || ac != 0) r = r + 6;
                if (r > 255) begin c = 1; r = r - 256; end
                if ((r / 16) > 9 || c != 0) r = r + 96;
                if (r > 255) c = 1;
                e.cy = c[0];
            end
        endcase
        e.res = 8'(r % 256);
        return e;
    endfunction

    task automatic drive(input int op, input int a, input int b,
                         input int cy, input int ac, input int ov, input string tag);
        @(negedge clk);
        op_i   = 4'(op);
        acc_i  = 8'(a);
        opnd_i = 8'(b);
        cy_i   = cy[0];
        ac_i   = ac[0];
        ov_i   = ov[0];
        sb_q.push_back(model(op, a, b, cy, ac, ov, tag));
    endtask

    // monitor: one result per stimulus, compared half a period after it was applied
    always @(posedge clk) begin
        if (!rst && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_checks++;
            if (res_o !== e.res || cy_o !== e.cy || ac_o !== e.ac || ov_o !== e.ov) begin
                n_errors++;
                $display("FAIL %s: got res=%h cy=%b ac=%b ov=%b expected res=%h cy=%b ac=%b ov=%b",
                         e.tag, res_o, cy_o, ac_o, ov_o, e.res, e.cy, e.ac, e.ov);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; op_i = 4'd8; acc_i = 8'h00; opnd_i = 8'h00;
        cy_i = 1'b0; ac_i = 1'b0; ov_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        drive(8, 8'h5A, 8'h00, 0, 0, 0, "R8 clear");
        drive(0, 8'h7F, 8'h01, 1, 0, 0, "R1 add ignores cy, R5 ov");
        drive(0, 8'hFF, 8'h01, 0, 0, 1, "R1 add carry, R4 ac");
        drive(0, 8'h80, 8'h80, 0, 1, 0, "R1 add neg overflow, R5");
        drive(1, 8'h0F, 8'h00, 1, 0, 0, "R2 addc cy into bit 3, R4");
        drive(1, 8'hFE, 8'h01, 1, 0, 0, "R2 addc wrap");
        drive(2, 8'h10, 8'h01, 0, 0, 0, "R3 subb half borrow, R4");
        drive(2, 8'h00, 8'h00, 1, 0, 0, "R3 subb borrow only");
        drive(2, 8'h80, 8'h01, 0, 0, 0, "R3 subb signed overflow, R5");
        drive(2, 8'h55, 8'h22, 1, 1, 1, "R3 subb no borrow");
        drive(3, 8'hFF, 8'h00, 1, 1, 1, "R6 inc wrap flags held");
        drive(4, 8'h00, 8'h00, 0, 1, 0, "R6 dec wrap flags held");
        drive(5, 8'hF0, 8'h3C, 1, 0, 1, "R7 and");
        drive(6, 8'hF0, 8'h3C, 0, 1, 1, "R7 or");
        drive(7, 8'hF0, 8'h3C, 1, 1, 0, "R7 xor");
        drive(9, 8'hA5, 8'h00, 1, 0, 1, "R8 complement");
        drive(10, 8'h81, 8'h00, 0, 0, 0, "R9 rotate left");
        drive(12, 8'h01, 8'h00, 1, 1, 1, "R9 rotate right");
        drive(11, 8'h80, 8'h00, 0, 1, 0, "R10 rlc out of bit 7");
        drive(11, 8'h00, 8'h00, 1, 0, 1, "R10 rlc cy into bit 0");
        drive(13, 8'h01, 8'h00, 0, 0, 1, "R10 rrc out of bit 0");
        drive(13, 8'h00, 8'h00, 1, 1, 0, "R10 rrc cy into bit 7");
        drive(14, 8'h3C, 8'h00, 1, 0, 1, "R11 swap");
        drive(15, 8'h9A, 8'h00, 0, 0, 0, "R12 da both nibbles, R13 carry set");
        drive(15, 8'h25, 8'h00, 0, 1, 1, "R12 da ac forces low fix");
        drive(15, 8'h12, 8'h00, 1, 0, 0, "R12 da cy forces high fix, R13 kept");
        drive(15, 8'h45, 8'h00, 0, 0, 1, "R13 da no fix clears nothing");
        drive(15, 8'hFA, 8'h00, 0, 0, 0, "R12 da low fix carries out");
        drive(15, 8'h0B, 8'h00, 0, 0, 0, "R12 da low only");
        for (int i = 0; i < 16; i++)
            drive(i, 8'h99 - i, 8'h37 + 3 * i, i % 2, (i / 2) % 2, (i / 4) % 2, "R1 sweep");

        repeat (3) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule